// File: doc/BRIEF.md
# Global exception status register

This block gathers fault events from two processing engines and their shared memories into one 32-bit control and status word. Every source has a sticky flag. A single request line, `exc_req_o`, is high while any flag that counts toward it is set. System software reads the word to find the cause. It then writes a 1 to the top bit, which clears every flag and drops the request in one access.

The event inputs are one-cycle pulses:
- a data-memory read error, qualified by who made the read;
- a watchdog expiry, one per engine;
- a firmware-raised exception, one per engine;
- an illegal-condition event, one per engine;
- a code-memory signature mismatch.

A read error made by the host is dropped. Only errors from engine reads are logged. The mismatch source has a software enable bit that decides whether it takes part in the request. The mismatch flag is recorded whether or not the enable is set.

The register port is one word wide and has no address. Writes take effect at the clock edge. The read data is always driven and reflects the register state.

Top module: `exc_status_reg`

## Requirements
- R1: After reset every status flag reads 0, the mismatch enable (bit 9) reads 0, `exc_req_o` is 0, and bits 20..16 read the parameter `SIZE_CFG`.
- R2: A pulse on `mem_rd_err_i` with `mem_rd_by_eng_i`=1 sets bit 30. A pulse with `mem_rd_by_eng_i`=0 changes neither bit 30 nor `exc_req_o`.
- R3: A pulse on `wdog_to_i[0]` sets bit 29. A pulse on `wdog_to_i[1]` sets bit 28.
- R4: A pulse on `fw_exc_i[0]` sets bit 27. A pulse on `fw_exc_i[1]` sets bit 26.
- R5: A pulse on `illegal_i[0]` sets bit 25. A pulse on `illegal_i[1]` sets bit 24.
- R6: Every flag stays set in the cycles after its event until a global clear.
- R7: A write with bit 31 = 1 clears bits 30..24 and bit 10, and drops `exc_req_o`. A write with bit 31 = 0 leaves all flags as they are. The clear does not change the enable bit.
- R8: If a source event and a global clear fall in the same cycle, the flag for that event is 1 afterwards and `exc_req_o` stays 1.
- R9: A `sig_mis_i` pulse sets bit 10 whatever the enable is. Bit 9 is read/write and takes the value of `reg_wdata_i[9]` on each write.
- R10: Writes to bits 30..24, 20..16 and 10 have no effect. Bit 31, bits 23..21, bits 15..11 and bits 8..0 always read 0.
- R11: `exc_req_o` is 1 exactly when at least one of bits 30..24 is set, or when bit 10 and bit 9 are both set. It rises in the cycle after the event edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rd_err_i | input | 1 | Data-memory read error pulse |
| mem_rd_by_eng_i | input | 1 | 1 = the failed read came from an engine, 0 = from the host |
| wdog_to_i | input | 2 | Watchdog expiry pulse per engine |
| fw_exc_i | input | 2 | Firmware-raised exception pulse per engine |
| illegal_i | input | 2 | Illegal-condition pulse per engine |
| sig_mis_i | input | 1 | Code-memory signature mismatch pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| exc_req_o | output | 1 | Global exception request |

## Verification
The hardest case to reach is a clear write that lands in the same edge as fresh events. This can happen on several sources at once, or on the mismatch source while its enable is being changed by that same write. The bench builds these cases on purpose. It schedules clear writes aligned with chosen event pulses. It then runs a long pseudo-random phase in which writes carrying bit 31 and bit 9 overlap sparse pulses on every source. A behavioural model checks the word and the request after every edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_ENG = 2;
  localparam int NUM_SRC = 8;

  // flag vector order
  localparam int SRC_MEM = 0;
  localparam int SRC_WD0 = 1;
  localparam int SRC_WD1 = 2;
  localparam int SRC_FW0 = 3;
  localparam int SRC_FW1 = 4;
  localparam int SRC_IL0 = 5;
  localparam int SRC_IL1 = 6;
  localparam int SRC_MIS = 7;

  // register bit positions
  localparam int B_CLR    = 31;
  localparam int B_MEM    = 30;
  localparam int B_WD0    = 29;
  localparam int B_WD1    = 28;
  localparam int B_FW0    = 27;
  localparam int B_FW1    = 26;
  localparam int B_IL0    = 25;
  localparam int B_IL1    = 24;
  localparam int B_SZ_LO  = 16;
  localparam int SZ_W     = 5;
  localparam int B_MIS    = 10;
  localparam int B_MIS_EN = 9;
endpackage

// File: rtl/exc_flag_bank.sv
module exc_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;  // event beats clear
      else if (clr_i)     flag_q[i] <= 1'b0;
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i) |=> flag_q[i]);
    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    // R7
    clr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[i]) |=> !flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/exc_csr_map.sv
module exc_csr_map
  import exc_pkg::*;
#(
  parameter logic [SZ_W-1:0] SIZE_CFG = 5'd8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               wr_clr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] flag_i,
  output logic               clr_o,
  output logic               mis_en_o,
  output logic [31:0]        rdata_o
);
  logic mis_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mis_en_q <= 1'b0;
    else if (we_i) mis_en_q <= wr_en_i;
  end

  assign clr_o    = we_i & wr_clr_i;
  assign mis_en_o = mis_en_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[B_MEM] = flag_i[SRC_MEM];
    rdata_o[B_WD0] = flag_i[SRC_WD0];
    rdata_o[B_WD1] = flag_i[SRC_WD1];
    rdata_o[B_FW0] = flag_i[SRC_FW0];
    rdata_o[B_FW1] = flag_i[SRC_FW1];
    rdata_o[B_IL0] = flag_i[SRC_IL0];
    rdata_o[B_IL1] = flag_i[SRC_IL1];
    rdata_o[B_SZ_LO +: SZ_W] = SIZE_CFG;
    rdata_o[B_MIS]    = flag_i[SRC_MIS];
    rdata_o[B_MIS_EN] = mis_en_q;
  end

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mis_en_q));
  // R9
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mis_en_q == $past(wr_en_i)));
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter logic [SZ_W-1:0] SIZE_CFG = 5'd8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mem_rd_err_i,
  input  logic               mem_rd_by_eng_i,
  input  logic [NUM_ENG-1:0] wdog_to_i,
  input  logic [NUM_ENG-1:0] fw_exc_i,
  input  logic [NUM_ENG-1:0] illegal_i,
  input  logic               sig_mis_i,
  input  logic               reg_we_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               exc_req_o
);
  logic [NUM_SRC-1:0] ev, flags;
  logic clr, mis_en;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[30:10], reg_wdata_i[8:0]};

  always_comb begin
    ev = '0;
    ev[SRC_MEM] = mem_rd_err_i & mem_rd_by_eng_i;  // host reads not logged
    ev[SRC_WD0] = wdog_to_i[0];
    ev[SRC_WD1] = wdog_to_i[1];
    ev[SRC_FW0] = fw_exc_i[0];
    ev[SRC_FW1] = fw_exc_i[1];
    ev[SRC_IL0] = illegal_i[0];
    ev[SRC_IL1] = illegal_i[1];
    ev[SRC_MIS] = sig_mis_i;
  end

  exc_flag_bank #(.W(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev),
    .clr_i  (clr),
    .flag_o (flags)
  );

  exc_csr_map #(.SIZE_CFG(SIZE_CFG)) u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .wr_clr_i (reg_wdata_i[B_CLR]),
    .wr_en_i  (reg_wdata_i[B_MIS_EN]),
    .flag_i   (flags),
    .clr_o    (clr),
    .mis_en_o (mis_en),
    .rdata_o  (reg_rdata_o)
  );

  assign exc_req_o = (|flags[SRC_IL1:SRC_MEM]) | (flags[SRC_MIS] & mis_en);

  // R2
  host_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_err_i && !mem_rd_by_eng_i && !reg_rdata_o[B_MEM]) |=> !reg_rdata_o[B_MEM]);
  // R11
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> $past((|ev) || reg_we_i));
  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_rdata_o[B_CLR] == 1'b0 && reg_rdata_o[23:21] == 3'b0));
endmodule

// File: tb/exc_status_reg_tb.sv
module exc_status_reg_tb_top;
  localparam logic [4:0] SIZE = 5'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_err = 0, mem_eng = 0, mis = 0, we = 0;
  logic [1:0] wd = 0, fw = 0, il = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic req;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // behavioural model
  bit m_mem, m_wd0, m_wd1, m_fw0, m_fw1, m_il0, m_il1, m_mis, m_en;

  always #5 clk = ~clk;

  exc_status_reg #(.SIZE_CFG(SIZE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_rd_err_i(mem_err), .mem_rd_by_eng_i(mem_eng),
    .wdog_to_i(wd), .fw_exc_i(fw), .illegal_i(il), .sig_mis_i(mis),
    .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .exc_req_o(req)
  );

  function automatic bit upd(bit cur, bit ev, bit clr);
    if (ev) return 1'b1;   // R8: event wins over clear
    if (clr) return 1'b0;  // R7
    return cur;            // R6
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_mem, m_wd0, m_wd1, m_fw0, m_fw1, m_il0, m_il1, m_mis, m_en} <= '0;
    end else begin
      bit c;
      c = we && wdata[31];
      m_mem <= upd(m_mem, mem_err && mem_eng, c);  // R2
      m_wd0 <= upd(m_wd0, wd[0], c);               // R3
      m_wd1 <= upd(m_wd1, wd[1], c);
      m_fw0 <= upd(m_fw0, fw[0], c);               // R4
      m_fw1 <= upd(m_fw1, fw[1], c);
      m_il0 <= upd(m_il0, il[0], c);               // R5
      m_il1 <= upd(m_il1, il[1], c);
      m_mis <= upd(m_mis, mis, c);                 // R9
      if (we) m_en <= wdata[9];
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[30] = m_mem; r[29] = m_wd0; r[28] = m_wd1;
    r[27] = m_fw0; r[26] = m_fw1; r[25] = m_il0; r[24] = m_il1;
    r[20:16] = SIZE;  // R1
    r[10] = m_mis; r[9] = m_en;  // R10: all else 0
    return r;
  endfunction

  function automatic logic exp_req();
    // R11
    return m_mem | m_wd0 | m_wd1 | m_fw0 | m_fw1 | m_il0 | m_il1 | (m_mis & m_en);
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    checks++;
    if (rdata !== exp_rd()) begin
      fails++;
      $display("FAIL %s rdata act=%h exp=%h cyc=%0d", tag, rdata, exp_rd(), cyc);
    end
    checks++;
    if (req !== exp_req()) begin
      fails++;
      $display("FAIL %s req act=%b exp=%b cyc=%0d", tag, req, exp_req(), cyc);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear_all();
    mem_err = 0; mem_eng = 0; wd = 0; fw = 0; il = 0; mis = 0; we = 0;
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0; wdata = 0;
  endtask

  task automatic direct_check(bit cond, string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  initial begin
    idle(2);
    // R1 reset state
    direct_check(rdata == {11'b0, SIZE, 16'b0} && !req, "R1", rdata, {11'b0, SIZE, 16'b0});
    @(negedge clk); rst_n = 1;
    idle(2);

    // R2 host read error ignored
    tag = "R2";
    @(negedge clk); mem_err = 1; mem_eng = 0;
    @(negedge clk); pulse_clear_all();
    direct_check(!rdata[30] && !req, "R2 host", {31'b0, req}, 32'b0);
    @(negedge clk); mem_err = 1; mem_eng = 1;
    @(negedge clk); pulse_clear_all();
    direct_check(rdata[30] && req, "R2 engine", rdata, 32'h4000_0000);
    idle(3);
    // R6 sticky
    direct_check(rdata[30], "R6", rdata, 32'h4000_0000);
    wr(32'h0000_0000);  // R7 write of 0 keeps flags
    direct_check(rdata[30] && req, "R7 keep", rdata, 32'h4000_0000);
    wr(32'h8000_0000);
    direct_check(rdata[30] == 0 && !req, "R7 clear", rdata, 32'h0);

    // R3 R4 R5 per-engine positions
    tag = "R3";
    @(negedge clk); wd = 2'b01; @(negedge clk); pulse_clear_all();
    direct_check(rdata[29:24] == 6'b100000, "R3 wd0", rdata, 32'h2000_0000);
    @(negedge clk); wd = 2'b10; @(negedge clk); pulse_clear_all();
    direct_check(rdata[29:24] == 6'b110000, "R3 wd1", rdata, 32'h3000_0000);
    tag = "R4";
    @(negedge clk); fw = 2'b01; @(negedge clk); pulse_clear_all();
    @(negedge clk); fw = 2'b10; @(negedge clk); pulse_clear_all();
    direct_check(rdata[27:26] == 2'b11, "R4", rdata, 32'h3C00_0000);
    tag = "R5";
    @(negedge clk); il = 2'b01; @(negedge clk); pulse_clear_all();
    direct_check(rdata[25:24] == 2'b10, "R5 il0", rdata, 32'h3E00_0000);
    @(negedge clk); il = 2'b10; @(negedge clk); pulse_clear_all();
    direct_check(rdata[25:24] == 2'b11, "R5 il1", rdata, 32'h3F00_0000);

    // R10 writes to read-only / reserved bits ignored
    tag = "R10";
    wr(32'h7FFF_FDFF);
    direct_check((rdata & 32'h80E0_F9FF) == 0 && rdata[20:16] == SIZE && rdata[29:24] == 6'h3F,
                 "R10", rdata, 32'h3F08_0000);

    // R8 event with clear in same cycle
    tag = "R8";
    @(negedge clk); we = 1; wdata = 32'h8000_0000; wd = 2'b10;
    @(negedge clk); we = 0; wdata = 0; pulse_clear_all();
    direct_check(rdata[29:24] == 6'b010000 && req, "R8", rdata, 32'h1008_0000);
    wr(32'h8000_0000);

    // R9 mismatch flag and enable gating
    tag = "R9";
    @(negedge clk); mis = 1; @(negedge clk); pulse_clear_all();
    direct_check(rdata[10] && !req, "R9 gated", rdata, 32'h0008_0400);
    wr(32'h0000_0200);
    direct_check(rdata[9] && req, "R9 enabled", rdata, 32'h0008_0600);
    wr(32'h8000_0200);
    direct_check(!rdata[10] && rdata[9] && !req, "R9 clear keeps en", rdata, 32'h0008_0200);
    // R8 mismatch together with clear and enable drop
    @(negedge clk); we = 1; wdata = 32'h8000_0000; mis = 1;
    @(negedge clk); pulse_clear_all(); wdata = 0;
    direct_check(rdata[10] && !rdata[9] && !req, "R8 mis", rdata, 32'h0008_0400);
    wr(32'h8000_0000);

    // R11 random overlap of events, clears and enable writes
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      mem_err = ($urandom_range(0, 15) == 0);
      mem_eng = $urandom_range(0, 1) == 1;
      wd  = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      fw  = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      il  = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      mis = ($urandom_range(0, 9) == 0);
      we  = ($urandom_range(0, 5) == 0);
      wdata = $urandom();
    end
    @(negedge clk); pulse_clear_all(); wdata = 0;
    idle(3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule